// File: doc/BRIEF.md
# Multigame Cartridge Mapper Register File

This block holds the configuration state of a multigame cartridge mapper and decodes CPU writes into it. It keeps four 8-bit bank masks (an AND mask and an XOR mask for program space, and the same pair for pattern space), an 8-bit control register and an 8-bit user bank register. The banking and nametable logic downstream reads these values continuously. This block does none of the bank arithmetic and does no nametable routing.

The masks are written through the $5000-$5FFF window. One address bit within that window also loads the control register with the same data byte, so a single store can set a mask and the control byte together. The user register sits in the upper CPU space. Two control bits decide at run time whether it also answers in the $6000-$7FFF window, and whether stores in $8000-$FFFF suffer a bus conflict with the program ROM. When a bus conflict applies, the stored value is the AND of the CPU byte and the ROM byte. The block also raises a write enable for the optional program RAM in $6000-$7FFF.

Top module: `mcm_mapper_regs`

## Requirements
- R1: While reset is active, and right after it is released, all four masks, the control register and the user register read zero.
- R2: A strobed write whose address has 0101 in bits 15..12 loads the mask chosen by address bits 1..0: 0 selects the program AND mask, 1 the program XOR mask, 2 the pattern AND mask and 3 the pattern XOR mask. The other masks keep their values. When address bit 2 is 0, the control register also keeps its value.
- R3: When address bit 2 is 1 in such a write, the control register takes the same byte as the selected mask. Its fields are: bit 7 conflict enable, bit 6 fixed-bank enable, bit 5 low-window enable, bits 4..2 nametable RAM enables and bits 1..0 mirroring source select.
- R4: When control bit 5 is 0, strobed writes in $8000-$FFFF load the user register and writes in $6000-$7FFF leave it unchanged.
- R5: When control bit 5 is 1, strobed writes in $6000-$7FFF also load the user register.
- R6: When control bit 7 is 1, a user write in $8000-$FFFF stores the CPU data ANDed with the ROM read data.
- R7: A user write in $6000-$7FFF stores the raw CPU data even when control bit 7 is 1.
- R8: Writes in $5000-$5FFF store the raw CPU data whatever control bit 7 and the ROM data hold.
- R9: The program RAM write enable is high exactly while the strobe is high with an address in $6000-$7FFF, when the RAM is present. This holds whatever control bit 5 holds.
- R10: No register changes in a cycle without the write strobe. Strobed writes in $0000-$4FFF change no register.
- R11: When control bit 7 is 0, a user write in $8000-$FFFF stores the raw CPU data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| rom_rdata | input | 8 | Program ROM data at cpu_addr, used for bus conflicts |
| prg_and_mask | output | 8 | Program bank AND mask |
| prg_xor_mask | output | 8 | Program bank XOR mask |
| chr_and_mask | output | 8 | Pattern bank AND mask |
| chr_xor_mask | output | 8 | Pattern bank XOR mask |
| user_bank | output | 8 | User bank register |
| conflict_en | output | 1 | Control bit 7 |
| fixed_bank_en | output | 1 | Control bit 6 |
| user_low_win | output | 1 | Control bit 5 |
| nt_ram_en | output | 3 | Control bits 4..2 |
| mirror_sel | output | 2 | Control bits 1..0 |
| prg_ram_we | output | 1 | Program RAM write enable, combinational |

## Verification
The assertions check the per-cycle rules on every cycle. These are: mask loading by the low address bits, the control load gated by address bit 2, the AND-with-ROM store when conflicts are enabled, the raw store through the low window, the user register holding when the low window is off, and the hold of every register without a strobe. The bench's scenarios alone show how the rules combine over a sequence of writes. Examples are a control write that moves the user window, and then a later store landing or not landing in the user register. They also show that every one of the sixteen address pages routes correctly under all four settings of the window and conflict bits.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 16;
    localparam int N_MASK  = 4;
    localparam int SEL_W   = $clog2(N_MASK);
    localparam int NT_W    = 3;
    localparam int MIR_W   = 2;

    // control byte field positions
    localparam int CTL_CONFLICT = 7;
    localparam int CTL_FIXED    = 6;
    localparam int CTL_LOWWIN   = 5;
    localparam int CTL_NT_LO    = 2;
    localparam int CTL_MIR_LO   = 0;

    typedef enum logic [SEL_W-1:0] {
        MSK_PRG_AND = 2'd0,
        MSK_PRG_XOR = 2'd1,
        MSK_CHR_AND = 2'd2,
        MSK_CHR_XOR = 2'd3
    } mask_sel_e;

    typedef struct packed {
        logic [N_MASK-1:0][REG_W-1:0] mask;
        logic [REG_W-1:0]             ctrl;
        logic [REG_W-1:0]             user;
    } regs_t;
endpackage

// File: rtl/mcm_addr_decode.sv
module mcm_addr_decode
    import mcm_pkg::*;
#(
    parameter bit HAS_PRG_RAM = 1'b1
) (
    input  logic              we,
    input  logic [3:0]        page,
    input  logic [SEL_W:0]    low_bits,
    input  logic              low_win_en,
    output logic [N_MASK-1:0] mask_wr,
    output logic              ctrl_wr,
    output logic              user_wr,
    output logic              high_zone,
    output logic              ram_wr
);
    logic sup_zone;
    logic low_zone;

    assign sup_zone  = (page == 4'h5);
    assign low_zone  = (page[3:1] == 3'b011);
    assign high_zone = page[3];

    for (genvar g = 0; g < N_MASK; g++) begin : g_mask_sel
        assign mask_wr[g] = we & sup_zone & (low_bits[SEL_W-1:0] == SEL_W'(g));
    end

    assign ctrl_wr = we & sup_zone & low_bits[SEL_W];
    assign user_wr = we & (high_zone | (low_zone & low_win_en));

    if (HAS_PRG_RAM) begin : g_ram
        assign ram_wr = we & low_zone;
    end else begin : g_no_ram
        assign ram_wr = 1'b0;
    end
endmodule

// File: rtl/mcm_bus_conflict.sv
module mcm_bus_conflict #(
    parameter int W = 8
) (
    input  logic [W-1:0] cpu_data,
    input  logic [W-1:0] rom_data,
    input  logic         apply,
    output logic [W-1:0] eff_data
);
    always_comb begin
        eff_data = cpu_data;
        if (apply) begin
            eff_data = cpu_data & rom_data;
        end
    end
endmodule

// File: rtl/mcm_mapper_regs.sv
module mcm_mapper_regs
    import mcm_pkg::*;
#(
    parameter bit HAS_PRG_RAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    input  logic              cpu_we,
    input  logic [REG_W-1:0]  rom_rdata,
    output logic [REG_W-1:0]  prg_and_mask,
    output logic [REG_W-1:0]  prg_xor_mask,
    output logic [REG_W-1:0]  chr_and_mask,
    output logic [REG_W-1:0]  chr_xor_mask,
    output logic [REG_W-1:0]  user_bank,
    output logic              conflict_en,
    output logic              fixed_bank_en,
    output logic              user_low_win,
    output logic [NT_W-1:0]   nt_ram_en,
    output logic [MIR_W-1:0]  mirror_sel,
    output logic              prg_ram_we
);
    regs_t regs_d;
    regs_t regs_q;

    logic [N_MASK-1:0] mask_wr;
    logic              ctrl_wr;
    logic              user_wr;
    logic              high_zone;
    logic [REG_W-1:0]  user_data;
    logic              unused_addr_mid;

    assign unused_addr_mid = ^cpu_addr[ADDR_W-5:SEL_W+1];

    mcm_addr_decode #(.HAS_PRG_RAM(HAS_PRG_RAM)) u_dec (
        .we         (cpu_we),
        .page       (cpu_addr[ADDR_W-1:ADDR_W-4]),
        .low_bits   (cpu_addr[SEL_W:0]),
        .low_win_en (regs_q.ctrl[CTL_LOWWIN]),
        .mask_wr    (mask_wr),
        .ctrl_wr    (ctrl_wr),
        .user_wr    (user_wr),
        .high_zone  (high_zone),
        .ram_wr     (prg_ram_we)
    );

    mcm_bus_conflict #(.W(REG_W)) u_conf (
        .cpu_data (cpu_wdata),
        .rom_data (rom_rdata),
        .apply    (high_zone & regs_q.ctrl[CTL_CONFLICT]),
        .eff_data (user_data)
    );

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N_MASK; i++) begin
            if (mask_wr[i]) begin
                regs_d.mask[i] = cpu_wdata;
            end
        end
        if (ctrl_wr) begin
            regs_d.ctrl = cpu_wdata;
        end
        if (user_wr) begin
            regs_d.user = user_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign prg_and_mask  = regs_q.mask[MSK_PRG_AND];
    assign prg_xor_mask  = regs_q.mask[MSK_PRG_XOR];
    assign chr_and_mask  = regs_q.mask[MSK_CHR_AND];
    assign chr_xor_mask  = regs_q.mask[MSK_CHR_XOR];
    assign user_bank     = regs_q.user;
    assign conflict_en   = regs_q.ctrl[CTL_CONFLICT];
    assign fixed_bank_en = regs_q.ctrl[CTL_FIXED];
    assign user_low_win  = regs_q.ctrl[CTL_LOWWIN];
    assign nt_ram_en     = regs_q.ctrl[CTL_NT_LO +: NT_W];
    assign mirror_sel    = regs_q.ctrl[CTL_MIR_LO +: MIR_W];
endmodule

// File: rtl/mcm_mapper_regs_chk.sv
module mcm_mapper_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [7:0]  rom_rdata,
    input logic [7:0]  prg_and_mask,
    input logic [7:0]  prg_xor_mask,
    input logic [7:0]  chr_and_mask,
    input logic [7:0]  chr_xor_mask,
    input logic [7:0]  user_bank,
    input logic        conflict_en,
    input logic        fixed_bank_en,
    input logic        user_low_win,
    input logic [2:0]  nt_ram_en,
    input logic [1:0]  mirror_sel,
    input logic        prg_ram_we
);
    logic [3:0][7:0] masks;
    logic [7:0]      ctrl;
    logic            sup_w;
    logic            low_w;
    logic            high_w;

    assign masks  = {chr_xor_mask, chr_and_mask, prg_xor_mask, prg_and_mask};
    assign ctrl   = {conflict_en, fixed_bank_en, user_low_win, nt_ram_en, mirror_sel};
    assign sup_w  = cpu_we && (cpu_addr[15:12] == 4'h5);
    assign low_w  = cpu_we && (cpu_addr[15:13] == 3'b011);
    assign high_w = cpu_we && cpu_addr[15];

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |-> (masks == '0 && ctrl == 8'h00 && user_bank == 8'h00));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sup_w |=> masks[$past(cpu_addr[1:0])] == $past(cpu_wdata));

    p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_w && !cpu_addr[2]) |=> $stable(ctrl));

    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_w && cpu_addr[2]) |=> ctrl == $past(cpu_wdata));

    p_user_nolow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_w && !user_low_win) |=> $stable(user_bank));

    p_user_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_w && user_low_win) |=> user_bank == $past(cpu_wdata));

    p_conflict_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (high_w && conflict_en) |=> user_bank == $past(cpu_wdata & rom_rdata));

    p_ram_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ram_we |-> low_w);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> ($stable(masks) && $stable(ctrl) && $stable(user_bank)));

    p_raw_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (high_w && !conflict_en) |=> user_bank == $past(cpu_wdata));
endmodule

bind mcm_mapper_regs mcm_mapper_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_we        (cpu_we),
    .rom_rdata     (rom_rdata),
    .prg_and_mask  (prg_and_mask),
    .prg_xor_mask  (prg_xor_mask),
    .chr_and_mask  (chr_and_mask),
    .chr_xor_mask  (chr_xor_mask),
    .user_bank     (user_bank),
    .conflict_en   (conflict_en),
    .fixed_bank_en (fixed_bank_en),
    .user_low_win  (user_low_win),
    .nt_ram_en     (nt_ram_en),
    .mirror_sel    (mirror_sel),
    .prg_ram_we    (prg_ram_we)
);

// File: tb/mcm_mapper_regs_bench.sv
module mcm_mapper_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  rom_rdata = '0;
    logic [7:0]  prg_and_mask, prg_xor_mask, chr_and_mask, chr_xor_mask, user_bank;
    logic        conflict_en, fixed_bank_en, user_low_win, prg_ram_we;
    logic [2:0]  nt_ram_en;
    logic [1:0]  mirror_sel;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0] m_mask [4];
    logic [7:0] m_ctrl;
    logic [7:0] m_user;

    always #10 clk = ~clk;

    mcm_mapper_regs u_mcm_mapper_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_we        (cpu_we),
        .rom_rdata     (rom_rdata),
        .prg_and_mask  (prg_and_mask),
        .prg_xor_mask  (prg_xor_mask),
        .chr_and_mask  (chr_and_mask),
        .chr_xor_mask  (chr_xor_mask),
        .user_bank     (user_bank),
        .conflict_en   (conflict_en),
        .fixed_bank_en (fixed_bank_en),
        .user_low_win  (user_low_win),
        .nt_ram_en     (nt_ram_en),
        .mirror_sel    (mirror_sel),
        .prg_ram_we    (prg_ram_we)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check8(req, "prg_and", prg_and_mask, m_mask[0]);
        check8(req, "prg_xor", prg_xor_mask, m_mask[1]);
        check8(req, "chr_and", chr_and_mask, m_mask[2]);
        check8(req, "chr_xor", chr_xor_mask, m_mask[3]);
        check8(req, "ctrl",
               {conflict_en, fixed_bank_en, user_low_win, nt_ram_en, mirror_sel}, m_ctrl);
        check8(req, "user", user_bank, m_user);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_mask[i] = 8'h00;
        m_ctrl = 8'h00;
        m_user = 8'h00;
    endtask

    // one strobed write, then compare every register
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
        string req;
        logic  low;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; rom_rdata = r; cpu_we = 1'b1;
        low = (a[15:13] == 3'b011);
        if (a[15:12] == 4'h5)  req = m_ctrl[7] ? "R8" : (a[2] ? "R3" : "R2");
        else if (low)          req = m_ctrl[5] ? (m_ctrl[7] ? "R7" : "R5") : "R4";
        else if (a[15])        req = m_ctrl[7] ? "R6" : "R11";
        else                   req = "R10";
        #1;
        check8("R9", "prg_ram_we", {7'd0, prg_ram_we}, {7'd0, low});
        // expected state from the requirements
        if (a[15:12] == 4'h5) begin
            m_mask[a[1:0]] = d;
            if (a[2]) m_ctrl = d;
        end else if (a[15] || (low && m_ctrl[5])) begin
            m_user = (a[15] && m_ctrl[7]) ? (d & r) : d;
        end
        @(negedge clk);
        cpu_we = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; rom_rdata = ~d; cpu_we = 1'b0;
        #1;
        check8("R10", "prg_ram_we idle", {7'd0, prg_ram_we}, 8'h00);
        @(negedge clk);
        check_all("R10");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h3C;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // mask and control sweep: every select, both bit-2 values
        for (int s = 0; s < 4; s++) begin
            for (int b2 = 0; b2 < 2; b2++) begin
                for (int p = 0; p < 5; p++) begin
                    logic [7:0] d;
                    d = pats[p] ^ 8'(s * 17);
                    d[7] = 1'b0;
                    wr(16'h5000 | (16'(d) << 4) | 16'(b2 << 2) | 16'(s), d, ~d);
                end
            end
        end

        // page sweep under every window/conflict setting
        for (int cfg = 0; cfg < 4; cfg++) begin
            wr(16'h5004 | 16'(cfg), {cfg[1], 1'b1, cfg[0], 5'b10110}, 8'h00);
            for (int pg = 0; pg < 16; pg++) begin
                logic [7:0] d;
                logic [7:0] r;
                d = 8'hC6 ^ 8'(pg * 29);
                r = 8'h5B ^ 8'(pg << 1);
                wr({4'(pg), 12'h3A9}, d, r);
                wr({4'(pg), 12'hF10}, ~d, r ^ 8'hF0);
                idle({4'(pg), 12'h777}, d);
            end
        end

        // conflict on mask window: bit 7 set, ROM zero, raw data must land
        wr(16'h5084, 8'hC1, 8'h00);
        wr(16'h5003, 8'h7E, 8'h00);
        wr(16'h9000, 8'hF0, 8'h3C);
        wr(16'h6000, 8'h99, 8'h00);

        // reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        wr(16'h7FFF, 8'h42, 8'h00);
        wr(16'hFFFF, 8'h42, 8'h0F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule